// File: doc/BRIEF.md
# Two-Register Multicycle Processor with Saturating Subtract

This block is a tiny von Neumann processor. Program and data live together in one external 32-word, 9-bit memory, which the block reaches over a single-port interface with one cycle of read latency. Each instruction is read from memory, decoded and carried out over several clock cycles. The block holds two working registers (A and B), a 5-bit program counter, an instruction register and a one-bit error flag.

The instruction set has five instructions. LOAD reads memory into a register and STORE writes a register to memory. SUB subtracts B from A; on underflow it clamps the result to zero and raises the error flag. JE branches when that flag is set. STOP ends the program. The three unused opcodes also halt the processor, and a separate status output marks that case. A synchronous reset loads the program counter from an input, so a program can start anywhere in memory.

Top module: `toy_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears A, B and the error flag, loads the PC from `start_pc`, and drops `halted` and `illegal`. In the first cycle after reset, `mem_addr` equals `start_pc`.
- R2: An instruction word uses bits [8:6] as the opcode, bit [5] as the register select (0 = A, 1 = B) and bits [4:0] as the operand. Fetch drives the PC onto `mem_addr` for one cycle. The next cycle receives the word and increments the PC. The cycle after that executes the instruction.
- R3: LOAD (010) drives the operand address in its execute cycle. In the following cycle it copies `mem_rdata` into the selected register and clears the error flag.
- R4: STORE (011) asserts `mem_we` for exactly its execute cycle, with the operand on `mem_addr` and the selected register on `mem_wdata`. It clears the error flag.
- R5: SUB (101) with B ≤ A writes A−B into A and clears the error flag. The register bit and operand bits are ignored.
- R6: SUB with B > A writes 0 into A and sets the error flag.
- R7: JE (110) with the error flag set loads the operand into the PC and clears the flag.
- R8: JE with the error flag clear leaves the incremented PC unchanged and keeps the flag clear.
- R9: STOP (111) ignores its low six bits. In the cycle after its execute cycle `halted` rises and stays high, and no memory write follows.
- R10: Opcodes 000, 001 and 100 halt the block with both `halted` and `illegal` high and perform no write.
- R11: The PC increments modulo 32, so a fetch at address 31 is followed by a fetch at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_pc | input | 5 | PC value loaded during reset |
| mem_addr | output | 5 | Memory address |
| mem_wdata | output | 9 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 9 | Memory read data, valid the cycle after the address |
| halted | output | 1 | High once execution has ended |
| illegal | output | 1 | High when the halt came from an undefined opcode |

## Verification
Assertions check several things on every cycle:
- the saturating-subtract result and the error flag it produces;
- the JE target;
- the PC increment and its wrap;
- the fetch address just after reset;
- that a halted block never writes and that `illegal` never appears without `halted`.

Other behaviour can only be seen through the bench's programs. Examples are LOAD and STORE clearing a pending error so that a later JE falls through, the exact bus trace of each instruction, and the final memory image. The bench's model runs each program itself and compares the bus against it on every clock.

// File: rtl/toy_cpu_pkg.sv
package toy_cpu_pkg;
    localparam int OPC_W = 3;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 3'b010;
    localparam logic [OPC_W-1:0] OPC_STORE = 3'b011;
    localparam logic [OPC_W-1:0] OPC_SUB   = 3'b101;
    localparam logic [OPC_W-1:0] OPC_JE    = 3'b110;
    localparam logic [OPC_W-1:0] OPC_STOP  = 3'b111;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_FWAIT,
        ST_EXEC,
        ST_LWAIT,
        ST_HALT
    } cpu_state_e;

    typedef enum logic [2:0] {
        K_LOAD,
        K_STORE,
        K_SUB,
        K_JE,
        K_STOP,
        K_ILLEGAL
    } ikind_e;
endpackage

// File: rtl/toy_cpu_decode.sv
module toy_cpu_decode
    import toy_cpu_pkg::*;
#(
    parameter int ADDR_W = 5,
    localparam int DATA_W = ADDR_W + OPC_W + 1
) (
    input  logic [DATA_W-1:0] instr,
    output ikind_e            kind,
    output logic              reg_sel,
    output logic [ADDR_W-1:0] operand
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc     = instr[DATA_W-1 -: OPC_W];
        reg_sel = instr[ADDR_W];
        operand = instr[ADDR_W-1:0];
        unique case (opc)
            OPC_LOAD:  kind = K_LOAD;
            OPC_STORE: kind = K_STORE;
            OPC_SUB:   kind = K_SUB;
            OPC_JE:    kind = K_JE;
            OPC_STOP:  kind = K_STOP;
            default:   kind = K_ILLEGAL; // 000, 001, 100 (R10)
        endcase
    end
endmodule

// File: rtl/toy_cpu_satsub.sv
module toy_cpu_satsub #(
    parameter int W = 9
) (
    input  logic [W-1:0] minuend,
    input  logic [W-1:0] subtrahend,
    output logic [W-1:0] result,
    output logic         borrow
);
    logic [W:0] wide;

    always_comb begin
        wide   = {1'b0, minuend} - {1'b0, subtrahend};
        borrow = wide[W];
        result = borrow ? '0 : wide[W-1:0];
    end
endmodule

// File: rtl/toy_cpu.sv
module toy_cpu
    import toy_cpu_pkg::*;
#(
    parameter int ADDR_W = 5,
    localparam int DATA_W = ADDR_W + OPC_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] start_pc,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted,
    output logic              illegal
);
    typedef struct packed {
        cpu_state_e        st;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] ra;
        logic [DATA_W-1:0] rb;
        logic              err;
        logic              halted;
        logic              illegal;
    } cpu_t;

    cpu_t q, d;

    ikind_e            kind;
    logic              reg_sel;
    logic [ADDR_W-1:0] operand;
    logic [DATA_W-1:0] sub_res;
    logic              sub_borrow;

    toy_cpu_decode #(.ADDR_W(ADDR_W)) i_decode (
        .instr   (q.ir),
        .kind    (kind),
        .reg_sel (reg_sel),
        .operand (operand)
    );

    toy_cpu_satsub #(.W(DATA_W)) i_satsub (
        .minuend    (q.ra),
        .subtrahend (q.rb),
        .result     (sub_res),
        .borrow     (sub_borrow)
    );

    always_comb begin
        d         = q;
        mem_addr  = q.pc;
        mem_we    = 1'b0;
        mem_wdata = reg_sel ? q.rb : q.ra;
        unique case (q.st)
            ST_FETCH: d.st = ST_FWAIT;
            ST_FWAIT: begin
                d.ir = mem_rdata;
                d.pc = q.pc + 1'b1;
                d.st = ST_EXEC;
            end
            ST_EXEC: begin
                d.st = ST_FETCH;
                unique case (kind)
                    K_LOAD: begin
                        mem_addr = operand;
                        d.st     = ST_LWAIT;
                    end
                    K_STORE: begin
                        mem_addr = operand;
                        mem_we   = 1'b1;
                        d.err    = 1'b0;
                    end
                    K_SUB: begin
                        d.ra  = sub_res;
                        d.err = sub_borrow;
                    end
                    K_JE: begin
                        if (q.err) d.pc = operand;
                        d.err = 1'b0;
                    end
                    K_STOP: begin
                        d.st     = ST_HALT;
                        d.halted = 1'b1;
                    end
                    default: begin
                        d.st      = ST_HALT;
                        d.halted  = 1'b1;
                        d.illegal = 1'b1;
                    end
                endcase
            end
            ST_LWAIT: begin
                if (reg_sel) d.rb = mem_rdata;
                else         d.ra = mem_rdata;
                d.err = 1'b0;
                d.st  = ST_FETCH;
            end
            default: d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.st <= ST_FETCH;
            q.pc <= start_pc;
        end else begin
            q <= d;
        end
    end

    assign halted  = q.halted;
    assign illegal = q.illegal;

    p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_addr == $past(start_pc) && !halted && !illegal))
        else $error("R1 fetch address after reset");

    p_sub_result_r5: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_EXEC && kind == K_SUB && q.rb <= q.ra)
        |=> (!q.err && q.ra == $past(q.ra) - $past(q.rb)))
        else $error("R5 subtract result");

    p_sub_floor_r6: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_EXEC && kind == K_SUB && q.rb > q.ra) |=> (q.err && q.ra == '0))
        else $error("R6 underflow clamp");

    p_je_taken_r7: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_EXEC && kind == K_JE && q.err) |=> (q.pc == $past(operand) && !q.err))
        else $error("R7 jump target");

    p_pc_step_r11: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_FWAIT) |=> (q.pc == ADDR_W'($past(q.pc) + 1'b1)))
        else $error("R11 pc increment");

    p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(q.ra) && $stable(q.rb)))
        else $error("R9 halt not sticky");

    p_halt_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we)
        else $error("R9 write while halted");

    p_illegal_halts_r10: assert property (@(posedge clk) disable iff (rst)
        illegal |-> halted)
        else $error("R10 illegal without halt");
endmodule

// File: tb/test_toy_cpu.sv
module test_toy_cpu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] start_pc = '0;
    logic [4:0] mem_addr;
    logic [8:0] mem_wdata;
    logic       mem_we;
    logic [8:0] mem_rdata;
    logic       halted;
    logic       illegal;

    int errors = 0;
    int checks = 0;

    logic [8:0] ram [32];
    logic [8:0] img [32];
    logic [8:0] mfin [32];
    bit         fin_ill;
    logic       tb_we = 1'b0;
    logic [4:0] tb_addr = '0;
    logic [8:0] tb_data = '0;

    always #2.5 clk = ~clk;

    toy_cpu i_toy_cpu (
        .clk(clk), .rst(rst), .start_pc(start_pc),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .halted(halted), .illegal(illegal)
    );

    always @(posedge clk) begin
        if (tb_we) ram[tb_addr] <= tb_data;
        else if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    typedef struct {
        bit         chk;
        logic [4:0] addr;
        bit         we;
        logic [8:0] wd;
        bit         hlt;
        bit         ill;
        int         tag;
    } exp_t;
    exp_t exq[$];

    function automatic logic [8:0] enc(input logic [2:0] op, input logic r, input logic [4:0] o);
        return {op, r, o};
    endfunction

    task automatic push(input bit c, input logic [4:0] a, input bit w,
                        input logic [8:0] wd, input bit h, input bit il, input int tg);
        exp_t e;
        e.chk = c; e.addr = a; e.we = w; e.wd = wd; e.hlt = h; e.ill = il; e.tag = tg;
        exq.push_back(e);
    endtask

    task automatic check(input bit ok, input int tg, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s actual=%0d expected=%0d", tg, what, act, expv);
        end
    endtask

    // Behavioural model: runs the program instruction by instruction and
    // lists the bus activity expected in each cycle.
    // Tags: R2 fetch, R11 fetch at 31, R3 LOAD, R4 STORE, R5/R6 SUB,
    // R7/R8 JE, R9 STOP, R10 undefined opcode.
    task automatic build(input int start);
        logic [8:0] m [32];
        int pc, ra, rb, err, op, rs, opd, tg;
        bit done, ill;
        m = img; pc = start; ra = 0; rb = 0; err = 0; done = 0; ill = 0;
        exq.delete();
        for (int n = 0; n < 100 && !done; n++) begin
            op = int'(m[pc][8:6]); rs = int'(m[pc][5]); opd = int'(m[pc][4:0]);
            tg = (pc == 31) ? 11 : 2;
            push(1, 5'(pc), 0, 0, 0, 0, tg);
            push(0, 0, 0, 0, 0, 0, tg);
            pc = (pc + 1) % 32;
            case (op)
                2: begin
                    push(1, 5'(opd), 0, 0, 0, 0, 3);
                    push(0, 0, 0, 0, 0, 0, 3);
                    if (rs == 1) rb = int'(m[opd]); else ra = int'(m[opd]);
                    err = 0;
                end
                3: begin
                    push(1, 5'(opd), 1, 9'(rs == 1 ? rb : ra), 0, 0, 4);
                    m[opd] = 9'(rs == 1 ? rb : ra);
                    err = 0;
                end
                5: begin
                    if (rb > ra) begin ra = 0; err = 1; tg = 6; end
                    else begin ra = ra - rb; err = 0; tg = 5; end
                    push(0, 0, 0, 0, 0, 0, tg);
                end
                6: begin
                    push(0, 0, 0, 0, 0, 0, (err == 1) ? 7 : 8);
                    if (err == 1) pc = opd;
                    err = 0;
                end
                7: begin push(0, 0, 0, 0, 0, 0, 9); done = 1; end
                default: begin push(0, 0, 0, 0, 0, 0, 10); done = 1; ill = 1; end
            endcase
        end
        for (int k = 0; k < 4; k++) push(0, 0, 0, 0, 1, ill, ill ? 10 : 9);
        mfin = m;
        fin_ill = ill;
    endtask

    task automatic run(input int start);
        @(negedge clk);
        rst = 1'b1;
        start_pc = 5'(start);
        for (int i = 0; i < 32; i++) begin
            tb_we = 1'b1; tb_addr = 5'(i); tb_data = img[i];
            @(negedge clk);
        end
        tb_we = 1'b0;
        build(start);
        // R1: reset state is visible at the ports
        check(!halted && !illegal, 1, "halted/illegal under reset", int'(halted), 0);
        rst = 1'b0;
        check(mem_addr == 5'(start), 1, "first fetch address", int'(mem_addr), start);
        while (exq.size() > 0) begin
            exp_t e;
            e = exq.pop_front();
            check(halted == e.hlt, e.tag, "halted", int'(halted), int'(e.hlt));
            check(illegal == e.ill, e.tag, "illegal", int'(illegal), int'(e.ill));
            check(mem_we == e.we, e.tag, "mem_we", int'(mem_we), int'(e.we));
            if (e.chk) check(mem_addr == e.addr, e.tag, "mem_addr", int'(mem_addr), int'(e.addr));
            if (e.we)  check(mem_wdata == e.wd, e.tag, "mem_wdata", int'(mem_wdata), int'(e.wd));
            @(negedge clk);
        end
        for (int i = 0; i < 32; i++)
            check(ram[i] == mfin[i], 4, $sformatf("memory word %0d", i), int'(ram[i]), int'(mfin[i]));
    endtask

    task automatic mem_is(input int a, input int v, input int tg);
        check(ram[a] == 9'(v), tg, $sformatf("hand value at %0d", a), int'(ram[a]), v);
    endtask

    task automatic clear_img();
        for (int i = 0; i < 32; i++) img[i] = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R9 watchdog expired actual=running expected=halted");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // S1: plain subtract, JE fall-through, underflow then JE taken (R5 R6 R7 R8)
        clear_img();
        img[4] = 9'd7; img[5] = 9'd5; img[7] = 9'd3; img[8] = 9'd5; img[9] = 9'h1FF;
        img[12] = enc(3'b010, 0, 5'd4);
        img[13] = enc(3'b010, 1, 5'd5);
        img[14] = enc(3'b101, 1, 5'd21);
        img[15] = enc(3'b011, 0, 5'd6);
        img[16] = enc(3'b110, 0, 5'd2);
        img[17] = enc(3'b010, 0, 5'd7);
        img[18] = enc(3'b010, 1, 5'd8);
        img[19] = enc(3'b101, 0, 5'd0);
        img[20] = enc(3'b110, 0, 5'd0);
        img[21] = enc(3'b111, 0, 5'd0);
        img[0]  = enc(3'b011, 0, 5'd9);
        img[1]  = enc(3'b011, 1, 5'd10);
        img[2]  = enc(3'b111, 0, 5'd0);
        run(12);
        mem_is(6, 2, 5); mem_is(9, 0, 6); mem_is(10, 5, 7);
        check(!illegal, 9, "stop is not illegal", int'(illegal), 0);

        // S2: PC wrap, LOAD clears error, undefined opcode 100 (R11 R3 R10)
        clear_img();
        img[20] = 9'd3; img[21] = 9'd9; img[22] = 9'h1FF;
        img[30] = enc(3'b010, 0, 5'd20);
        img[31] = enc(3'b010, 1, 5'd21);
        img[0]  = enc(3'b101, 0, 5'd0);
        img[1]  = enc(3'b010, 1, 5'd20);
        img[2]  = enc(3'b110, 0, 5'd10);
        img[3]  = enc(3'b011, 0, 5'd22);
        img[4]  = enc(3'b011, 1, 5'd23);
        img[5]  = enc(3'b100, 1, 5'd10);
        img[10] = enc(3'b111, 0, 5'd0);
        run(30);
        mem_is(22, 0, 6); mem_is(23, 3, 3);
        check(illegal && halted, 10, "opcode 100 halts illegal", int'(illegal), 1);

        // S3: equal operands give zero without error; STOP with junk low bits (R5 R9)
        clear_img();
        img[16] = 9'd200; img[17] = 9'h1FF;
        img[0] = enc(3'b010, 0, 5'd16);
        img[1] = enc(3'b010, 1, 5'd16);
        img[2] = enc(3'b101, 0, 5'd0);
        img[3] = enc(3'b110, 0, 5'd9);
        img[4] = enc(3'b011, 0, 5'd17);
        img[5] = enc(3'b111, 1, 5'd31);
        img[9] = enc(3'b001, 0, 5'd0);
        run(0);
        mem_is(17, 0, 5);
        check(halted && !illegal, 9, "stop with junk bits", int'(illegal), 0);

        // S4: STORE clears a pending error so JE falls through (R4 R8)
        clear_img();
        img[20] = 9'd1; img[21] = 9'd2;
        img[0] = enc(3'b010, 0, 5'd20);
        img[1] = enc(3'b010, 1, 5'd21);
        img[2] = enc(3'b101, 0, 5'd0);
        img[3] = enc(3'b011, 1, 5'd22);
        img[4] = enc(3'b110, 0, 5'd9);
        img[5] = enc(3'b111, 0, 5'd0);
        img[9] = enc(3'b000, 0, 5'd0);
        run(0);
        mem_is(22, 2, 4);
        check(!illegal, 8, "JE not taken after STORE", int'(illegal), 0);

        // S5/S6: undefined opcodes 001 and 000 (R10)
        clear_img();
        img[7] = enc(3'b001, 0, 5'd3);
        run(7);
        check(illegal, 10, "opcode 001", int'(illegal), 1);
        clear_img();
        img[31] = enc(3'b000, 1, 5'd31);
        run(31);
        check(illegal, 10, "opcode 000", int'(illegal), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule